// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits between a memory controller's command logic and its column address pins. It keeps a copy of the mode word that is written with a mode-register-set event, and from it decodes the burst length, the beat order, the read latency and the write mode. When a read or write command arrives with a starting column and a bank, the block produces one column address per clock for the length of the burst. Each beat comes with a valid strobe, the bank, the command direction and a flag that marks the final beat.

The first beat is presented in the same cycle as the command, at the commanded column. Later beats come from an internal counter: they either step upward inside an aligned block the size of the burst, or they XOR the beat index into the low column bits. A full-page burst walks every column of the row and wraps at the top. With single-write mode selected, a write produces exactly one beat while reads still burst. A new command cuts short any burst in progress. The decoded read latency is presented on its own output so that the read data path can schedule its capture.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: After reset the stored mode is burst length 1, sequential order, latency field 0 and burst write. On a cycle with `mode_set` high the 12-bit `mode_word` is stored; it governs commands from the next cycle on, and a command in the same cycle as `mode_set` uses the previous mode. Without `mode_set` the stored mode does not change.
- R2: In the cycle a command is presented (`cmd_valid` high), `beat_valid` is high and `beat_col`, `beat_bank` and `beat_write` equal `cmd_col`, `cmd_bank` and `cmd_write`. Bank and direction hold for every later beat of that burst.
- R3: The burst-length field `mode_word[2:0]` decodes as 000 = 1, 001 = 2, 010 = 4, 011 = 8 and 111 = full page (2^COL_W beats, 256 by default). The codes 100, 101 and 110 give length 1. The beats of a burst come on consecutive cycles.
- R4: With `mode_word[3]` = 0 (sequential), beat k of a burst of length L is at column (start − start mod L) + ((start mod L + k) mod L).
- R5: With `mode_word[3]` = 1 (interleaved) and a length of 2, 4 or 8, beat k is at column start XOR k.
- R6: A full-page burst is always sequential: beat k is at (start + k) mod 2^COL_W, whatever the value of `mode_word[3]`.
- R7: `beat_last` is high on the final beat of a burst and on no other beat. In the cycle after the final beat, `beat_valid` is low unless a new command is presented.
- R8: A write-mode field `mode_word[11:9]` of 001 (single write) makes each write command produce exactly one beat. Reads keep the programmed length. Any other value of the field (000 is the usual one) makes writes use the programmed length.
- R9: A command presented during a burst ends that burst at once, and the new burst begins in the same cycle from the new starting column with the current mode.
- R10: The length and order of a burst are fixed when its command arrives; a `mode_set` during the burst does not change the beats that remain.
- R11: `cas_latency` always equals bits [6:4] of the stored mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Store `mode_word` at this edge |
| mode_word | input | 12 | Mode word: [11:9] write mode, [6:4] latency, [3] order, [2:0] length |
| cmd_valid | input | 1 | A read or write command is presented this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W | Starting column of the command |
| cmd_bank | input | BANK_W | Bank of the command |
| beat_valid | output | 1 | A beat address is presented this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_bank | output | BANK_W | Bank of the current beat |
| beat_write | output | 1 | Direction of the current beat |
| beat_last | output | 1 | The current beat is the final one of its burst |
| cas_latency | output | 3 | Latency field of the stored mode word |

## Verification
The assertions take for granted that the inputs are two-valued after reset and that `cmd_col` and `cmd_bank` are meaningful whenever `cmd_valid` is high. They place no limits on when commands or mode writes may arrive, because truncation and a mode change in the middle of a burst are both defined behaviour. The stimulus changes inputs only on falling clock edges and samples the outputs just after, so each beat is seen once. It writes a mode before every scenario, including the same-cycle mode-and-command case, so that no check depends on the mode left behind by an earlier test.

// File: rtl/sba_pkg.sv
package sba_pkg;

   // Decoded contents of the stored mode word
   typedef struct packed {
      logic       single_wr;   // write-mode code 001
      logic [2:0] cas;         // read latency field
      logic       interleave;  // beat order select
      logic [2:0] len_code;    // burst length code
   } mode_t;

   localparam logic [2:0] LEN_1    = 3'b000;
   localparam logic [2:0] LEN_2    = 3'b001;
   localparam logic [2:0] LEN_4    = 3'b010;
   localparam logic [2:0] LEN_8    = 3'b011;
   localparam logic [2:0] LEN_PAGE = 3'b111;

   localparam logic [2:0] WMODE_SINGLE = 3'b001;

   localparam int MODE_BITS = 12;

endpackage

// File: rtl/sba_mode_reg.sv
module sba_mode_reg
   import sba_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_set,
   input  logic [MODE_BITS-1:0] mode_word,
   output mode_t                mode
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (mode_set) begin
         mode.single_wr  <= (mode_word[11:9] == WMODE_SINGLE);
         mode.cas        <= mode_word[6:4];
         mode.interleave <= mode_word[3];
         mode.len_code   <= mode_word[2:0];
      end
   end

   // R1: stored mode only moves on a mode write
   assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_set |=> $stable(mode));

endmodule

// File: rtl/sba_len_decode.sv
module sba_len_decode
   import sba_pkg::*;
#(
   parameter int COL_W = 8
)(
   input  logic [2:0]       len_code,
   output logic [COL_W-1:0] len_m1,
   output logic             full_page
);

   always_comb begin
      full_page = 1'b0;
      unique case (len_code)
         LEN_2:    len_m1 = COL_W'(1);
         LEN_4:    len_m1 = COL_W'(3);
         LEN_8:    len_m1 = COL_W'(7);
         LEN_PAGE: begin
            len_m1    = '1;
            full_page = 1'b1;
         end
         default:  len_m1 = '0;   // length 1, also reserved codes
      endcase
   end

endmodule

// File: rtl/sba_beat_seq.sv
module sba_beat_seq #(
   parameter int COL_W  = 8,
   parameter int BANK_W = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [COL_W-1:0]  new_len_m1,
   input  logic              new_inter,
   output logic              cur_valid,
   output logic [COL_W-1:0]  cur_idx,
   output logic [COL_W-1:0]  cur_start,
   output logic [COL_W-1:0]  cur_len_m1,
   output logic              cur_inter,
   output logic [BANK_W-1:0] cur_bank,
   output logic              cur_write,
   output logic              cur_last
);

   logic              act_q;
   logic [COL_W-1:0]  cnt_q;
   logic [COL_W-1:0]  start_q;
   logic [COL_W-1:0]  len_q;
   logic              inter_q;
   logic [BANK_W-1:0] bank_q;
   logic              write_q;

   // A command overrides stored burst state in its own cycle
   always_comb begin
      if (cmd_valid) begin
         cur_valid  = 1'b1;
         cur_idx    = '0;
         cur_start  = cmd_col;
         cur_len_m1 = new_len_m1;
         cur_inter  = new_inter;
         cur_bank   = cmd_bank;
         cur_write  = cmd_write;
      end else begin
         cur_valid  = act_q;
         cur_idx    = cnt_q;
         cur_start  = start_q;
         cur_len_m1 = len_q;
         cur_inter  = inter_q;
         cur_bank   = bank_q;
         cur_write  = write_q;
      end
      cur_last = cur_valid && (cur_idx == cur_len_m1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         cnt_q   <= '0;
         start_q <= '0;
         len_q   <= '0;
         inter_q <= 1'b0;
         bank_q  <= '0;
         write_q <= 1'b0;
      end else if (cmd_valid) begin
         act_q   <= (new_len_m1 != '0);
         cnt_q   <= COL_W'(1);
         start_q <= cmd_col;
         len_q   <= new_len_m1;
         inter_q <= new_inter;
         bank_q  <= cmd_bank;
         write_q <= cmd_write;
      end else if (act_q) begin
         cnt_q <= cnt_q + COL_W'(1);
         if (cnt_q == len_q) act_q <= 1'b0;
      end
   end

   // R3: a running burst never indexes past its length
   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (cnt_q != '0) && (cnt_q <= len_q));

   // R10: captured length holds for the remaining beats
   assert_len_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !cmd_valid) |=> $stable(len_q) && $stable(inter_q));

endmodule

// File: rtl/sba_col_map.sv
module sba_col_map #(
   parameter int COL_W        = 8,
   parameter bit INTERLEAVE_EN = 1'b1
)(
   input  logic [COL_W-1:0] start,
   input  logic [COL_W-1:0] idx,
   input  logic [COL_W-1:0] len_m1,
   input  logic             inter,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] block_base;
   logic [COL_W-1:0] seq_off;

   assign block_base = start & ~len_m1;
   assign seq_off    = (start + idx) & len_m1;

   generate
      if (INTERLEAVE_EN) begin : g_both_orders
         logic [COL_W-1:0] int_off;
         assign int_off = (start ^ idx) & len_m1;
         assign col     = block_base | (inter ? int_off : seq_off);
      end else begin : g_seq_only
         logic unused_inter;
         assign unused_inter = inter;
         assign col          = block_base | seq_off;
      end
   endgenerate

endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
   import sba_pkg::*;
#(
   parameter int COL_W         = 8,
   parameter int BANK_W        = 1,
   parameter bit INTERLEAVE_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_set,
   input  logic [11:0]       mode_word,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic [BANK_W-1:0] cmd_bank,
   output logic              beat_valid,
   output logic [COL_W-1:0]  beat_col,
   output logic [BANK_W-1:0] beat_bank,
   output logic              beat_write,
   output logic              beat_last,
   output logic [2:0]        cas_latency
);

   generate
      if (COL_W < 3) begin : g_bad_col
         $error("COL_W must hold an 8-beat burst");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("BANK_W must be at least 1");
      end
   endgenerate

   mode_t            mode;
   logic [COL_W-1:0] prog_len_m1;
   logic             full_page;
   logic [COL_W-1:0] new_len_m1;
   logic             new_inter;
   logic [COL_W-1:0] cur_idx;
   logic [COL_W-1:0] cur_start;
   logic [COL_W-1:0] cur_len_m1;
   logic             cur_inter;

   sba_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_set  (mode_set),
      .mode_word (mode_word),
      .mode      (mode)
   );

   sba_len_decode #(.COL_W(COL_W)) u_len (
      .len_code  (mode.len_code),
      .len_m1    (prog_len_m1),
      .full_page (full_page)
   );

   // Single-write mode collapses writes to one beat; full page is sequential
   assign new_len_m1 = (cmd_write && mode.single_wr) ? '0 : prog_len_m1;
   assign new_inter  = mode.interleave && !full_page;

   sba_beat_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_write  (cmd_write),
      .cmd_col    (cmd_col),
      .cmd_bank   (cmd_bank),
      .new_len_m1 (new_len_m1),
      .new_inter  (new_inter),
      .cur_valid  (beat_valid),
      .cur_idx    (cur_idx),
      .cur_start  (cur_start),
      .cur_len_m1 (cur_len_m1),
      .cur_inter  (cur_inter),
      .cur_bank   (beat_bank),
      .cur_write  (beat_write),
      .cur_last   (beat_last)
   );

   sba_col_map #(.COL_W(COL_W), .INTERLEAVE_EN(INTERLEAVE_EN)) u_map (
      .start  (cur_start),
      .idx    (cur_idx),
      .len_m1 (cur_len_m1),
      .inter  (cur_inter),
      .col    (beat_col)
   );

   assign cas_latency = mode.cas;

   // R2: command cycle shows the commanded column and bank
   assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> beat_valid && (beat_col == cmd_col) && (beat_bank == cmd_bank));

   // R2: bank and direction hold across a burst
   assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last) |=>
         (cmd_valid || (beat_valid && $stable(beat_bank) && $stable(beat_write))));

   // R7: nothing follows the final beat unless a command arrives
   assert_burst_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_last) |=> (cmd_valid || !beat_valid));

   // R8: single-write writes are one beat long
   assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && mode.single_wr) |-> beat_last);

endmodule

// File: tb/sdram_burst_addr_gen_bench.sv
module sdram_burst_addr_gen_bench;

   localparam int  COL_W   = 8;
   localparam int  BANK_W  = 1;
   localparam int  PAGE    = 1 << COL_W;
   localparam time CLK_PER = 10ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_set = 1'b0;
   logic [11:0]       mode_word = '0;
   logic              cmd_valid = 1'b0;
   logic              cmd_write = 1'b0;
   logic [COL_W-1:0]  cmd_col = '0;
   logic [BANK_W-1:0] cmd_bank = '0;
   logic              beat_valid;
   logic [COL_W-1:0]  beat_col;
   logic [BANK_W-1:0] beat_bank;
   logic              beat_write;
   logic              beat_last;
   logic [2:0]        cas_latency;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PER/2) clk = ~clk;

   sdram_burst_addr_gen #(.COL_W(COL_W), .BANK_W(BANK_W)) u_sdram_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_word(mode_word),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
      .cmd_bank(cmd_bank), .beat_valid(beat_valid), .beat_col(beat_col),
      .beat_bank(beat_bank), .beat_write(beat_write), .beat_last(beat_last),
      .cas_latency(cas_latency)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // {write mode, 2'b00, latency, order, length}
   function automatic logic [11:0] mk_mode(input logic [2:0] wm, input logic [2:0] cl,
                                           input logic bt, input logic [2:0] bl);
      return {wm, 2'b00, cl, bt, bl};
   endfunction

   function automatic int exp_col(input int start, input int k, input int len, input bit inter);
      int base;
      if (len == PAGE) return (start + k) % PAGE;
      if (inter) return start ^ k;
      base = start - (start % len);
      return base + ((start % len) + k) % len;
   endfunction

   task automatic write_mode(input logic [11:0] w);
      @(negedge clk);
      mode_set  = 1'b1;
      mode_word = w;
      @(negedge clk);
      mode_set  = 1'b0;
   endtask

   // Issue a command and check every beat plus the idle cycle after it
   task automatic run_burst(input int start, input logic [BANK_W-1:0] bank, input bit wr,
                            input int len, input bit inter, input string req);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_write = wr;
      cmd_col   = COL_W'(start);
      cmd_bank  = bank;
      for (int k = 0; k < len; k++) begin
         if (k > 0) begin
            @(negedge clk);
            cmd_valid = 1'b0;
         end
         #1;
         check(beat_valid && beat_col == COL_W'(exp_col(start, k, len, inter)), req,
               int'(beat_col), exp_col(start, k, len, inter));
         check(beat_last == (k == len - 1), {req, " R7 last"}, int'(beat_last),
               int'(k == len - 1));
         check(beat_bank == bank && beat_write == wr, {req, " R2 bank/dir"},
               int'(beat_bank), int'(bank));
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      check(!beat_valid, {req, " R7 idle after burst"}, int'(beat_valid), 0);
   endtask

   task automatic t_reset;
      #1;
      check(!beat_valid, "R1 reset no beat", int'(beat_valid), 0);
      check(cas_latency == 3'd0, "R1 reset latency", int'(cas_latency), 0);
      run_burst(37, 1'b1, 1'b0, 1, 1'b0, "R1 reset length 1");
   endtask

   task automatic t_seq;
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b010));
      run_burst(6, 1'b0, 1'b0, 4, 1'b0, "R4 seq len4 start 6");
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b011));
      run_burst(13, 1'b1, 1'b1, 8, 1'b0, "R4 seq len8 start 13");
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b001));
      run_burst(9, 1'b0, 1'b0, 2, 1'b0, "R3 seq len2 start 9");
   endtask

   task automatic t_inter;
      write_mode(mk_mode(3'b000, 3'd3, 1'b1, 3'b011));
      run_burst(5, 1'b0, 1'b0, 8, 1'b1, "R5 interleave len8 start 5");
      write_mode(mk_mode(3'b000, 3'd3, 1'b1, 3'b010));
      run_burst(250, 1'b1, 1'b0, 4, 1'b1, "R5 interleave len4 start 250");
   endtask

   task automatic t_page;
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b111));
      run_burst(250, 1'b0, 1'b0, PAGE, 1'b0, "R6 full page start 250");
      write_mode(mk_mode(3'b000, 3'd2, 1'b1, 3'b111));
      run_burst(3, 1'b1, 1'b0, PAGE, 1'b0, "R6 full page ignores interleave");
   endtask

   task automatic t_reserved;
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b101));
      run_burst(20, 1'b0, 1'b0, 1, 1'b0, "R3 reserved code 101 is length 1");
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b110));
      run_burst(21, 1'b0, 1'b1, 1, 1'b0, "R3 reserved code 110 is length 1");
   endtask

   task automatic t_write_mode;
      write_mode(mk_mode(3'b001, 3'd2, 1'b0, 3'b010));
      run_burst(6, 1'b0, 1'b1, 1, 1'b0, "R8 single write one beat");
      run_burst(6, 1'b0, 1'b0, 4, 1'b0, "R8 single mode read bursts");
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b010));
      run_burst(6, 1'b1, 1'b1, 4, 1'b0, "R8 burst write uses length");
   endtask

   task automatic t_truncate;
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b011));
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'd0; cmd_bank = 1'b0;
      for (int k = 1; k < 3; k++) begin
         @(negedge clk);
         cmd_valid = 1'b0;
         #1;
         check(beat_col == 8'(k), "R9 before truncate", int'(beat_col), k);
      end
      run_burst(35, 1'b1, 1'b1, 8, 1'b0, "R9 new burst after truncate");
   endtask

   task automatic t_mode_mid_burst;
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b010));
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'd10; cmd_bank = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
      mode_set  = 1'b1;
      mode_word = mk_mode(3'b000, 3'd2, 1'b1, 3'b000);
      #1;
      check(beat_col == 8'd11, "R10 beat 1", int'(beat_col), 11);
      @(negedge clk);
      mode_set = 1'b0;
      #1;
      check(beat_valid && beat_col == 8'd8, "R10 beat 2 after mode write", int'(beat_col), 8);
      @(negedge clk);
      #1;
      check(beat_col == 8'd9 && beat_last, "R10 beat 3 last", int'(beat_col), 9);
      run_burst(10, 1'b0, 1'b0, 1, 1'b0, "R10 new mode applies to next command");
   endtask

   task automatic t_same_cycle;
      write_mode(mk_mode(3'b000, 3'd2, 1'b0, 3'b001));
      @(negedge clk);
      mode_set  = 1'b1;
      mode_word = mk_mode(3'b000, 3'd5, 1'b0, 3'b011);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'd40; cmd_bank = 1'b0;
      #1;
      check(!beat_last, "R1 same-cycle command uses old length 2", int'(beat_last), 0);
      @(negedge clk);
      mode_set = 1'b0; cmd_valid = 1'b0;
      #1;
      check(beat_col == 8'd41 && beat_last, "R1 old length ends at beat 1", int'(beat_col), 41);
      check(cas_latency == 3'd5, "R11 latency field", int'(cas_latency), 5);
      write_mode(mk_mode(3'b000, 3'd3, 1'b0, 3'b000));
      #1;
      check(cas_latency == 3'd3, "R11 latency rewrite", int'(cas_latency), 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_seq();
      t_inter();
      t_page();
      t_reserved();
      t_write_mode();
      t_truncate();
      t_mode_mid_burst();
      t_same_cycle();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule